// File: doc/BRIEF.md
# Breakpoint and Watchpoint Comparator

This block holds a bank of breakpoint slots for a processor core. Each slot pairs a compare value with a small control word. The control word enables the slot, picks the bus quantity to watch, sets the relation to test and selects signed or unsigned arithmetic. The bus quantity can be the fetch address, a load or store address, or load or store data.

Every cycle, each enabled slot compares its value with the chosen quantity. A slot can only match in a cycle where that quantity's valid strobe is high. The block returns registered per-slot match flags, a hit flag, and the index of the lowest-numbered matching slot. It also raises a fetch-break request when the matching set contains a slot that watches the fetch address. A debug host programs the slots through a simple write port and reads them back through a combinational read port. Chaining slots together and taking the exception are left to the core.

Top module: `dbg_bkpt_cmp`

## Requirements
- R1: After reset every slot value and control word reads zero, and match_o, hit_o, hit_idx_o and if_break_o are zero.
- R2: A write with cfg_ctrl_i=0 stores all DATA_W bits as the slot value. A write with cfg_ctrl_i=1 stores only bits 7:0 as the control word. Control reads return bits above 7 as zero, so the reserved bits are ignored.
- R3: Control bit 0 enables the slot. A slot with bit 0 clear never matches.
- R4: Control bits 3:1 choose the relation "quantity OP value". The codes are 001 equal, 010 less than, 011 less or equal, 100 greater than, 101 greater or equal and 110 not equal. Codes 000 and 111 never match.
- R5: Control bit 4 selects two's-complement comparison when set and unsigned comparison when clear.
- R6: Control bits 7:5 choose the quantity and the strobe that qualifies it. The codes are 001 fetch address with if_valid_i, 010 load address with ld_valid_i, 011 store address with st_valid_i, 100 load data with ld_valid_i, and 101 store data with st_valid_i. Codes 000 and 111 never match, and no slot matches while its strobe is low.
- R7: Source code 110 watches the load address when ld_valid_i is high, otherwise the store address when st_valid_i is high. The load address wins when both strobes are high.
- R8: match_o and hit_o reflect the bus inputs sampled at the previous rising clock edge. hit_o equals the OR of match_o.
- R9: hit_idx_o is the lowest index whose match flag is set.
- R10: if_break_o is high when at least one matching slot uses source code 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Slot write strobe |
| cfg_ctrl_i | input | 1 | Write target: 1 control word, 0 value |
| cfg_idx_i | input | IDX_W | Slot index for writes |
| cfg_wdata_i | input | DATA_W | Write data |
| cfg_ridx_i | input | IDX_W | Slot index for reads |
| cfg_rctrl_i | input | 1 | Read target: 1 control word, 0 value |
| cfg_rdata_o | output | DATA_W | Read data |
| if_valid_i | input | 1 | Fetch address valid |
| if_addr_i | input | DATA_W | Fetch address |
| ld_valid_i | input | 1 | Load valid |
| ld_addr_i | input | DATA_W | Load effective address |
| ld_data_i | input | DATA_W | Load data |
| st_valid_i | input | 1 | Store valid |
| st_addr_i | input | DATA_W | Store effective address |
| st_data_i | input | DATA_W | Store data |
| match_o | output | NUM_PAIRS | Registered per-slot match flags |
| hit_o | output | 1 | Registered: at least one slot matched |
| hit_idx_o | output | IDX_W | Registered index of the lowest matching slot |
| if_break_o | output | 1 | Registered fetch-break request |

## Verification
The bench builds the block with the defaults: four slots and 32-bit data. With four slots it can make slots 1 to 3 match together and check that the index skips the non-matching slot 0. It can also leave only slot 3 matching, so the highest index is reached. At 32 bits the values 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF sit on the sign boundary. There the signed and unsigned relations disagree, so every condition code is swept on both sides of a value.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  localparam int CTRL_W = 8;

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_IF_ADDR = 3'd1,
    SRC_LD_ADDR = 3'd2,
    SRC_ST_ADDR = 3'd3,
    SRC_LD_DATA = 3'd4,
    SRC_ST_DATA = 3'd5,
    SRC_LS_ADDR = 3'd6,
    SRC_RSVD    = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    CND_OFF  = 3'd0,
    CND_EQ   = 3'd1,
    CND_LT   = 3'd2,
    CND_LE   = 3'd3,
    CND_GT   = 3'd4,
    CND_GE   = 3'd5,
    CND_NE   = 3'd6,
    CND_RSVD = 3'd7
  } cond_e;

  // field order follows the control word bit layout, msb first
  typedef struct packed {
    src_e  src;
    logic  sgn;
    cond_e cond;
    logic  en;
  } ctrl_t;
endpackage

// File: rtl/dbg_pair_regs.sv
module dbg_pair_regs
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              ctrl_sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  input  logic              rctrl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] val_o  [NUM_PAIRS],
  output ctrl_t             ctrl_o [NUM_PAIRS]
);
  localparam int PAD_W = DATA_W - CTRL_W;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [DATA_W-1:0] val_q;
    ctrl_t             ctrl_q;
    logic              sel;

    assign sel = we_i && (idx_i == IDX_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q  <= '0;
        ctrl_q <= '0;
      end else if (sel) begin
        if (ctrl_sel_i) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        else            val_q  <= wdata_i;
      end
    end

    assign val_o[p]  = val_q;
    assign ctrl_o[p] = ctrl_q;
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (ridx_i == IDX_W'(p)) begin
        rdata_o = rctrl_i ? {{PAD_W{1'b0}}, ctrl_o[p]} : val_o[p];
      end
    end
  end
endmodule

// File: rtl/dbg_pair_cmp.sv
module dbg_pair_cmp
  import dbg_bkpt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              if_valid_i,
  input  logic [DATA_W-1:0] if_addr_i,
  input  logic              ld_valid_i,
  input  logic [DATA_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              st_valid_i,
  input  logic [DATA_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              match_o
);
  logic [DATA_W-1:0] qty;
  logic              qty_ok;
  logic              eq, lt, rel;

  always_comb begin
    qty    = '0;
    qty_ok = 1'b0;
    case (ctrl_i.src)
      SRC_IF_ADDR: begin qty = if_addr_i; qty_ok = if_valid_i; end
      SRC_LD_ADDR: begin qty = ld_addr_i; qty_ok = ld_valid_i; end
      SRC_ST_ADDR: begin qty = st_addr_i; qty_ok = st_valid_i; end
      SRC_LD_DATA: begin qty = ld_data_i; qty_ok = ld_valid_i; end
      SRC_ST_DATA: begin qty = st_data_i; qty_ok = st_valid_i; end
      SRC_LS_ADDR: begin
        qty    = ld_valid_i ? ld_addr_i : st_addr_i;  // load wins
        qty_ok = ld_valid_i | st_valid_i;
      end
      default: ;
    endcase
  end

  assign eq = (qty == val_i);
  assign lt = ctrl_i.sgn ? ($signed(qty) < $signed(val_i)) : (qty < val_i);

  always_comb begin
    case (ctrl_i.cond)
      CND_EQ:  rel = eq;
      CND_LT:  rel = lt;
      CND_LE:  rel = lt | eq;
      CND_GT:  rel = ~(lt | eq);
      CND_GE:  rel = ~lt;
      CND_NE:  rel = ~eq;
      default: rel = 1'b0;
    endcase
  end

  assign match_o = ctrl_i.en & qty_ok & rel;
endmodule

// File: rtl/dbg_prio_enc.sv
module dbg_prio_enc #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/dbg_bkpt_cmp.sv
module dbg_bkpt_cmp
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic                 cfg_ctrl_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [DATA_W-1:0]    cfg_wdata_i,
  input  logic [IDX_W-1:0]     cfg_ridx_i,
  input  logic                 cfg_rctrl_i,
  output logic [DATA_W-1:0]    cfg_rdata_o,
  input  logic                 if_valid_i,
  input  logic [DATA_W-1:0]    if_addr_i,
  input  logic                 ld_valid_i,
  input  logic [DATA_W-1:0]    ld_addr_i,
  input  logic [DATA_W-1:0]    ld_data_i,
  input  logic                 st_valid_i,
  input  logic [DATA_W-1:0]    st_addr_i,
  input  logic [DATA_W-1:0]    st_data_i,
  output logic [NUM_PAIRS-1:0] match_o,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     hit_idx_o,
  output logic                 if_break_o
);
  logic [DATA_W-1:0]    val   [NUM_PAIRS];
  ctrl_t                ctrl  [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] match_d;
  logic [NUM_PAIRS-1:0] fetch_src;
  logic                 any_d;
  logic [IDX_W-1:0]     idx_d;

  dbg_pair_regs #(
    .NUM_PAIRS(NUM_PAIRS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .ctrl_sel_i(cfg_ctrl_i),
    .idx_i     (cfg_idx_i),
    .wdata_i   (cfg_wdata_i),
    .ridx_i    (cfg_ridx_i),
    .rctrl_i   (cfg_rctrl_i),
    .rdata_o   (cfg_rdata_o),
    .val_o     (val),
    .ctrl_o    (ctrl)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_cmp
    dbg_pair_cmp #(.DATA_W(DATA_W)) u_cmp (
      .ctrl_i    (ctrl[p]),
      .val_i     (val[p]),
      .if_valid_i(if_valid_i),
      .if_addr_i (if_addr_i),
      .ld_valid_i(ld_valid_i),
      .ld_addr_i (ld_addr_i),
      .ld_data_i (ld_data_i),
      .st_valid_i(st_valid_i),
      .st_addr_i (st_addr_i),
      .st_data_i (st_data_i),
      .match_o   (match_d[p])
    );
    assign fetch_src[p] = (ctrl[p].src == SRC_IF_ADDR);
  end

  dbg_prio_enc #(
    .N    (NUM_PAIRS),
    .IDX_W(IDX_W)
  ) u_prio (
    .req_i(match_d),
    .any_o(any_d),
    .idx_o(idx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o    <= '0;
      hit_o      <= 1'b0;
      hit_idx_o  <= '0;
      if_break_o <= 1'b0;
    end else begin
      match_o    <= match_d;
      hit_o      <= any_d;
      hit_idx_o  <= idx_d;
      if_break_o <= |(match_d & fetch_src);
    end
  end
endmodule

// File: rtl/dbg_bkpt_cmp_chk.sv
module dbg_bkpt_cmp_chk #(
  parameter int NUM_PAIRS = 4,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_rctrl_i,
  input logic [DATA_W-1:0]    cfg_rdata_o,
  input logic                 if_valid_i,
  input logic                 ld_valid_i,
  input logic                 st_valid_i,
  input logic [NUM_PAIRS-1:0] match_o,
  input logic                 hit_o,
  input logic [IDX_W-1:0]     hit_idx_o,
  input logic                 if_break_o
);
  logic seen_q;
  logic any_v;

  assign any_v = if_valid_i | ld_valid_i | st_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rctrl_i |-> (cfg_rdata_o[DATA_W-1:8] == '0));

  p_no_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(any_v)) |-> (match_o == '0));

  p_hit_or_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (|match_o));

  p_idx_lowest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_o[hit_idx_o] &&
               ((match_o & ((NUM_PAIRS'(1) << hit_idx_o) - NUM_PAIRS'(1))) == '0)));

  p_break_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_break_o |-> hit_o);
endmodule

bind dbg_bkpt_cmp dbg_bkpt_cmp_chk #(
  .NUM_PAIRS(NUM_PAIRS),
  .DATA_W   (DATA_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_rctrl_i(cfg_rctrl_i),
  .cfg_rdata_o(cfg_rdata_o),
  .if_valid_i (if_valid_i),
  .ld_valid_i (ld_valid_i),
  .st_valid_i (st_valid_i),
  .match_o    (match_o),
  .hit_o      (hit_o),
  .hit_idx_o  (hit_idx_o),
  .if_break_o (if_break_o)
);

// File: tb/dbg_bkpt_cmp_tb_top.sv
`timescale 1ns/1ps
module dbg_bkpt_cmp_tb_top;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_ctrl = 1'b0, cfg_rctrl = 1'b0;
  logic [IW-1:0] cfg_idx = '0, cfg_ridx = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic          ifv = 1'b0, ldv = 1'b0, stv = 1'b0;
  logic [DW-1:0] ifa = '0, lda = '0, ldd = '0, sta = '0, std = '0;
  logic [NP-1:0] match;
  logic          hit, brk;
  logic [IW-1:0] hidx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_bkpt_cmp #(.NUM_PAIRS(NP), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_ctrl_i(cfg_ctrl), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .cfg_ridx_i(cfg_ridx), .cfg_rctrl_i(cfg_rctrl),
    .cfg_rdata_o(cfg_rdata),
    .if_valid_i(ifv), .if_addr_i(ifa),
    .ld_valid_i(ldv), .ld_addr_i(lda), .ld_data_i(ldd),
    .st_valid_i(stv), .st_addr_i(sta), .st_data_i(std),
    .match_o(match), .hit_o(hit), .hit_idx_o(hidx), .if_break_o(brk)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(int src, int cond, bit sgn, bit en);
    return {24'h0, src[2:0], sgn, cond[2:0], en};
  endfunction

  function automatic bit rel_ok(int c, bit s, logic [31:0] q, logic [31:0] v);
    bit eq = (q == v);
    bit lt = s ? ($signed(q) < $signed(v)) : (q < v);
    case (c)
      1: return eq;
      2: return lt;
      3: return lt || eq;
      4: return !lt && !eq;
      5: return !lt;
      6: return !eq;
      default: return 0;
    endcase
  endfunction

  task automatic wr(int idx, bit is_ctl, logic [31:0] d);
    @(negedge clk);
    ifv = 0; ldv = 0; stv = 0;
    cfg_we = 1; cfg_ctrl = is_ctl; cfg_idx = IW'(idx); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic rd(int idx, bit is_ctl, output logic [31:0] d);
    @(negedge clk);
    cfg_ridx = IW'(idx); cfg_rctrl = is_ctl;
    #1 d = cfg_rdata;
  endtask

  task automatic clear_all();
    for (int p = 0; p < NP; p++) begin
      wr(p, 1, 32'h0);
      wr(p, 0, 32'h0);
    end
  endtask

  task automatic bus(bit iv, logic [31:0] ia, bit lv, logic [31:0] la, logic [31:0] ld,
                     bit sv, logic [31:0] sa, logic [31:0] sd);
    @(negedge clk);
    ifv = iv; ifa = ia; ldv = lv; lda = la; ldd = ld; stv = sv; sta = sa; std = sd;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 match", 32'(match), 0);
    chk("R1 hit", 32'(hit), 0);
    chk("R1 idx", 32'(hidx), 0);
    chk("R1 brk", 32'(brk), 0);
    for (int p = 0; p < NP; p++) begin
      rd(p, 0, d); chk("R1 value", d, 0);
      rd(p, 1, d); chk("R1 ctrl", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2, 0, 32'hDEADBEEF);
    wr(2, 1, 32'hFFFFFF54);
    rd(2, 0, d); chk("R2 value", d, 32'hDEADBEEF);
    rd(2, 1, d); chk("R2 ctrl reserved", d, 32'h54);
    rd(1, 0, d); chk("R2 other slot", d, 0);
    clear_all();
  endtask

  task automatic t_enable();
    wr(0, 0, 32'h100);
    wr(0, 1, ctl(1, 1, 0, 0));
    bus(1, 32'h100, 0, 0, 0, 0, 0, 0);
    chk("R3 disabled", 32'(match), 0);
    chk("R3 disabled hit", 32'(hit), 0);
    wr(0, 1, ctl(1, 1, 0, 1));
    bus(1, 32'h100, 0, 0, 0, 0, 0, 0);
    chk("R3 enabled", 32'(match), 1);
    chk("R10 fetch break", 32'(brk), 1);
    // R8: inputs changed after the edge must not move the outputs yet
    @(negedge clk);
    ifv = 0;
    #1 chk("R8 held", 32'(hit), 1);
    @(posedge clk); #1;
    chk("R8 cleared", 32'(hit), 0);
    chk("R8 match cleared", 32'(match), 0);
    clear_all();
  endtask

  task automatic t_cond();
    logic [31:0] addrs [3] = '{32'hFF, 32'h100, 32'h101};
    wr(0, 0, 32'h100);
    for (int c = 0; c < 8; c++) begin
      wr(0, 1, ctl(1, c, 0, 1));
      for (int k = 0; k < 3; k++) begin
        bus(1, addrs[k], 0, 0, 0, 0, 0, 0);
        chk($sformatf("R4 cond%0d addr%0d", c, k), 32'(match[0]),
            32'(rel_ok(c, 0, addrs[k], 32'h100)));
      end
    end
    clear_all();
  endtask

  task automatic t_signed();
    logic [31:0] qs [3] = '{32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000};
    logic [31:0] vs [3] = '{32'h00000001, 32'h80000000, 32'h7FFFFFFF};
    for (int k = 0; k < 3; k++) begin
      wr(0, 0, vs[k]);
      for (int s = 0; s < 2; s++) begin
        for (int c = 2; c < 6; c++) begin
          wr(0, 1, ctl(1, c, s[0], 1));
          bus(1, qs[k], 0, 0, 0, 0, 0, 0);
          chk($sformatf("R5 case%0d sgn%0d cond%0d", k, s, c), 32'(match[0]),
              32'(rel_ok(c, s[0], qs[k], vs[k])));
        end
      end
    end
    clear_all();
  endtask

  task automatic t_src();
    localparam logic [31:0] V = 32'h12345678;
    localparam logic [31:0] W = 32'h0BADF00D;
    wr(0, 0, V);
    for (int s = 0; s < 8; s++) begin
      wr(0, 1, ctl(s, 1, 0, 1));
      // one field at a time holds the value, all strobes high
      for (int f = 1; f < 6; f++) begin
        bit e = (s == f) || (s == 6 && f == 2);
        bus(1, f == 1 ? V : W, 1, f == 2 ? V : W, f == 4 ? V : W,
            1, f == 3 ? V : W, f == 5 ? V : W);
        chk($sformatf("R6 src%0d field%0d", s, f), 32'(match[0]), 32'(e));
      end
      // all fields hold the value, strobes one at a time
      for (int g = 0; g < 4; g++) begin
        bit e = (g == 1 && s == 1) || (g == 2 && (s == 2 || s == 4 || s == 6)) ||
                (g == 3 && (s == 3 || s == 5 || s == 6));
        bus(g == 1, V, g == 2, V, V, g == 3, V, V);
        chk($sformatf("R6 src%0d strobe%0d", s, g), 32'(match[0]), 32'(e));
        chk($sformatf("R10 src%0d strobe%0d", s, g), 32'(brk), 32'(e && s == 1));
      end
    end
    clear_all();
  endtask

  task automatic t_ls();
    localparam logic [31:0] V = 32'hA000_0040;
    wr(0, 0, V);
    wr(0, 1, ctl(6, 1, 0, 1));
    bus(0, 0, 1, V, 0, 0, 0, 0);
    chk("R7 load only", 32'(match[0]), 1);
    bus(0, 0, 0, 0, 0, 1, V, 0);
    chk("R7 store only", 32'(match[0]), 1);
    bus(0, 0, 1, 32'h4, 0, 1, V, 0);
    chk("R7 load wins", 32'(match[0]), 0);
    bus(0, 0, 1, V, 0, 1, 32'h4, 0);
    chk("R7 load wins hit", 32'(match[0]), 1);
    chk("R10 no fetch", 32'(brk), 0);
    clear_all();
  endtask

  task automatic t_prio();
    localparam logic [31:0] V = 32'h0000_2000;
    for (int p = 0; p < NP; p++) begin
      wr(p, 0, p == 0 ? 32'h1 : V);
      wr(p, 1, ctl(1, 1, 0, 1));
    end
    bus(1, V, 0, 0, 0, 0, 0, 0);
    chk("R9 match set", 32'(match), 32'hE);
    chk("R9 lowest idx", 32'(hidx), 1);
    chk("R8 hit or", 32'(hit), 1);
    wr(1, 0, 32'h5);
    wr(2, 0, 32'h6);
    bus(1, V, 0, 0, 0, 0, 0, 0);
    chk("R9 top slot", 32'(hidx), 3);
    chk("R9 top match", 32'(match), 32'h8);
    wr(0, 0, V);
    wr(2, 1, ctl(2, 1, 0, 1));
    wr(2, 0, 32'h30);
    bus(1, V, 1, 32'h30, 0, 0, 0, 0);
    chk("R9 slot0", 32'(hidx), 0);
    chk("R9 mixed set", 32'(match), 32'hD);
    wr(0, 1, 0);
    wr(3, 1, 0);
    bus(1, V, 1, 32'h30, 0, 0, 0, 0);
    chk("R10 load slot only", 32'(brk), 0);
    chk("R10 load slot hit", 32'(hit), 1);
    clear_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_enable();
    t_cond();
    t_signed();
    t_src();
    t_ls();
    t_prio();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule